// File: doc/BRIEF.md
# Downstream Port Reset and High-Speed Chirp Sequencer

This block sits beside one downstream port of a hub. When asked to reset the port it commands the transceiver to drive SE0 for a fixed reset window. While SE0 is on the wire it listens for an attached device answering with a chirp K. A device chirp is accepted only after it has been held without a break for a filter time. Once that chirp stops, the block waits a short fixed delay and then drives hub chirps as K-J pairs. It starts a pair only if the pair and a minimum quiet SE0 tail still fit inside the window. At the end of the window it releases the line, pulses `done` and reports the resulting speed.

Every duration is a cycle-count parameter, so the same block can run with real timings or with short ones. A low-speed indication sampled with the request turns off the handshake. A disconnect seen during the sequence ends it at once and raises a one-cycle event instead of `done`.

Line codes on `line_st`: 0 = SE0, 1 = J, 2 = K, 3 = SE1. Drive codes on `drv_cmd`: 0 = idle, 1 = SE0, 2 = chirp K, 3 = chirp J. Speed codes on `spd`: 0 = full speed, 1 = low speed, 2 = high speed.

Top module: `port_reset_chirp_seq`

## Requirements
- R1: After reset, `drv_cmd` is 0 (idle), `done` and `disc_evt` are 0 and `spd` is 0 (full speed).
- R2: A request seen while idle makes `drv_cmd` non-idle from the next cycle. The drive then lasts exactly RST_CYC cycles and is followed by one cycle of idle with `done` = 1.
- R3: A device chirp K counts only after `line_st` = 2 has been sampled for FILT_CYC consecutive cycles while SE0 is driven. A shorter burst changes nothing, and SE0 stays on the line.
- R4: The first hub chirp K (`drv_cmd` = 2) starts exactly RESP_CYC+1 cycles after the first cycle in which the accepted device chirp K is no longer on the line.
- R5: Hub chirps alternate K then J, each lasting exactly CHIRP_CYC cycles, and are emitted only as complete pairs that start with K.
- R6: A pair is started only if its end plus GUARD_CYC cycles still fits in the reset window. The SE0 tail after the last pair is therefore at least GUARD_CYC and less than GUARD_CYC+2*CHIRP_CYC cycles long.
- R7: If `low_spd` is 1 when the request is accepted, device chirps are ignored, only SE0 is driven and `spd` reports 1 at `done`.
- R8: At `done`, `spd` is 2 if at least one hub pair was emitted, and 0 otherwise (unless R7 applies). `spd` holds its value until the next `done`.
- R9: `disc` = 1 during a non-idle cycle makes `drv_cmd` idle on the next cycle with `disc_evt` = 1 for one cycle, and no `done` follows.
- R10: A request that arrives while a sequence is running is ignored. The sequence keeps its timing and does not restart after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Request to reset the port |
| low_spd | input | 1 | Attached device is low speed; sampled with the request |
| disc | input | 1 | Disconnect seen on the port |
| line_st | input | 2 | Received line state code |
| drv_cmd | output | 2 | Drive command to the transceiver |
| done | output | 1 | One-cycle pulse when the reset window ends |
| spd | output | 2 | Resulting port speed, valid from `done` |
| disc_evt | output | 1 | One-cycle pulse when a disconnect aborts the sequence |

## Verification
The hardest case to reach from the ports is the pair-fit decision. Whether one more pair may start depends on exactly where the device chirp ended in the window. The bench reaches it in two ways. It places a device chirp so late that the filter still accepts it but no pair fits, which must give full speed. It places an early chirp whose pair train ends with a tail just above the guard length. The filter edge is probed with bursts one cycle shorter than the filter time and exactly as long as it. A reference model builds the expected drive code for every cycle from the placement of the chirp and compares it on each clock.

// File: rtl/rcs_pkg.sv
// Shared encodings for the port reset and chirp sequencer.
// Assumes: codes on the ports are the plain 2-bit values listed in the brief.
package rcs_pkg;
    typedef enum logic [1:0] {LN_SE0 = 2'd0, LN_J = 2'd1, LN_K = 2'd2, LN_SE1 = 2'd3} line_e;
    typedef enum logic [1:0] {DRV_IDLE = 2'd0, DRV_SE0 = 2'd1, DRV_K = 2'd2, DRV_J = 2'd3} drv_e;
    typedef enum logic [1:0] {SPD_FS = 2'd0, SPD_LS = 2'd1, SPD_HS = 2'd2, SPD_RSV = 2'd3} spd_e;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RST, ST_DEVK, ST_RESP, ST_HUBK, ST_HUBJ, ST_TAIL
    } st_e;
endpackage

// File: rtl/rcs_counter.sv
// Up-counter with synchronous clear, used for the reset window and phase timing.
// Assumes: the owner clears it before the count can wrap.
module rcs_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count cycles; clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rcs_kfilter.sv
// Filters the device chirp K: asserts hit on the FILT_CYC-th consecutive
// cycle of K while enabled. Any non-K cycle or disable restarts the count.
// Assumes: FILT_CYC >= 1.
module rcs_kfilter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic is_k,
    output logic hit
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

    logic [FW-1:0] kcnt;

    // Count consecutive K samples, saturating at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !is_k) kcnt <= '0;
        else if (kcnt != LAST)      kcnt <= kcnt + 1'b1;
    end

    assign hit = en && is_k && (kcnt == LAST);
endmodule

// File: rtl/rcs_fsm.sv
// Sequencer control: walks reset SE0, device chirp wait, response delay,
// hub K/J pairs and SE0 tail, and produces done, speed and disconnect event.
// Assumes: RST_CYC > 2*CHIRP_CYC + GUARD_CYC + RESP_CYC + FILT_CYC.
module rcs_fsm
    import rcs_pkg::*;
#(
    parameter int RST_CYC   = 600000,
    parameter int RESP_CYC  = 600,
    parameter int CHIRP_CYC = 3000,
    parameter int GUARD_CYC = 9000,
    parameter int RW        = 20,
    parameter int PW        = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          low_spd,
    input  logic          disc,
    input  logic          line_k,
    input  logic          k_hit,
    input  logic [RW-1:0] rst_cnt,
    input  logic [PW-1:0] ph_cnt,
    output st_e           st,
    output logic          ph_clr,
    output logic          filt_en,
    output logic          done,
    output logic [1:0]    spd,
    output logic          disc_evt
);
    localparam int LIMIT = RST_CYC - 2 * CHIRP_CYC - GUARD_CYC - 1;
    localparam logic [RW-1:0] RST_LAST = RW'(RST_CYC - 1);
    localparam logic [RW-1:0] ROOM_MAX = RW'(LIMIT);
    localparam logic [PW-1:0] RESP_LAST = PW'(RESP_CYC - 1);
    localparam logic [PW-1:0] CHIRP_LAST = PW'(CHIRP_CYC - 1);

    st_e  nxt;
    logic ls_q, hs_q;
    logic win_end, room, pair_end;

    assign win_end  = (rst_cnt == RST_LAST);
    assign room     = (rst_cnt <= ROOM_MAX);
    assign pair_end = (st == ST_HUBJ) && (ph_cnt == CHIRP_LAST);
    assign filt_en  = (st == ST_RST) && !ls_q;
    assign ph_clr   = (nxt != st);

    // Next-state selection; disconnect, then window end, take priority.
    always_comb begin
        nxt = st;
        if (st == ST_IDLE) begin
            if (req) nxt = ST_RST;
        end else if (disc || win_end) begin
            nxt = ST_IDLE;
        end else begin
            case (st)
                ST_RST:  if (k_hit) nxt = ST_DEVK;
                ST_DEVK: if (!line_k) nxt = ST_RESP;
                ST_RESP: if (ph_cnt == RESP_LAST) nxt = room ? ST_HUBK : ST_TAIL;
                ST_HUBK: if (ph_cnt == CHIRP_LAST) nxt = ST_HUBJ;
                ST_HUBJ: if (pair_end) nxt = room ? ST_HUBK : ST_TAIL;
                default: nxt = st;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Per-sequence flags: low speed captured at start, high speed after a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q <= 1'b0;
            hs_q <= 1'b0;
        end else if (st == ST_IDLE && req) begin
            ls_q <= low_spd;
            hs_q <= 1'b0;
        end else if (pair_end && !disc && !win_end) begin
            hs_q <= 1'b1;
        end
    end

    // Completion, abort event and speed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            disc_evt <= 1'b0;
            spd      <= SPD_FS;
        end else begin
            done     <= (st != ST_IDLE) && !disc && win_end;
            disc_evt <= (st != ST_IDLE) && disc;
            if ((st != ST_IDLE) && !disc && win_end)
                spd <= ls_q ? SPD_LS : (hs_q ? SPD_HS : SPD_FS);
        end
    end
endmodule

// File: rtl/port_reset_chirp_seq.sv
// Top of the downstream port reset and chirp sequencer. Connects the window
// and phase counters, the device chirp filter and the control machine, and
// decodes the drive command from the state.
// Assumes: line_st is synchronous to clk; durations are given in cycles.
module port_reset_chirp_seq
    import rcs_pkg::*;
#(
    parameter int RST_CYC   = 600000,
    parameter int FILT_CYC  = 150,
    parameter int RESP_CYC  = 600,
    parameter int CHIRP_CYC = 3000,
    parameter int GUARD_CYC = 9000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_req,
    input  logic       low_spd,
    input  logic       disc,
    input  logic [1:0] line_st,
    output logic [1:0] drv_cmd,
    output logic       done,
    output logic [1:0] spd,
    output logic       disc_evt
);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam int PMAX = (RESP_CYC > CHIRP_CYC) ? RESP_CYC : CHIRP_CYC;
    localparam int PW = $clog2(PMAX + 1);

    st_e           st;
    logic [RW-1:0] rst_cnt;
    logic [PW-1:0] ph_cnt;
    logic          ph_clr, filt_en, k_hit, line_k;

    assign line_k = (line_st == LN_K);

    rcs_counter #(.W(RW)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE), .inc(1'b1), .cnt(rst_cnt)
    );

    rcs_counter #(.W(PW)) u_ph_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .inc(1'b1), .cnt(ph_cnt)
    );

    rcs_kfilter #(.FILT_CYC(FILT_CYC)) u_kfilt (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .is_k(line_k), .hit(k_hit)
    );

    rcs_fsm #(
        .RST_CYC(RST_CYC), .RESP_CYC(RESP_CYC), .CHIRP_CYC(CHIRP_CYC),
        .GUARD_CYC(GUARD_CYC), .RW(RW), .PW(PW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(rst_req), .low_spd(low_spd), .disc(disc),
        .line_k(line_k), .k_hit(k_hit), .rst_cnt(rst_cnt), .ph_cnt(ph_cnt),
        .st(st), .ph_clr(ph_clr), .filt_en(filt_en), .done(done), .spd(spd),
        .disc_evt(disc_evt)
    );

    // Drive command decode from the current state.
    always_comb begin
        case (st)
            ST_IDLE: drv_cmd = DRV_IDLE;
            ST_HUBK: drv_cmd = DRV_K;
            ST_HUBJ: drv_cmd = DRV_J;
            default: drv_cmd = DRV_SE0;
        endcase
    end
endmodule

// File: rtl/rcs_checker.sv
// Temporal checks on the sequencer's ports, bound to every instance of the top.
// Assumes: rst_n is held low for at least one clock at start.
module rcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       disc,
    input logic [1:0] drv_cmd,
    input logic       done,
    input logic       disc_evt
);
    // R9: disconnect while busy aborts on the next cycle with an event.
    a_r9_disc_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (disc && drv_cmd != 2'd0) |=> (drv_cmd == 2'd0 && disc_evt));

    // R9: completion and abort never occur together.
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, disc_evt}));

    // R2/R6: the window always closes out of SE0.
    a_r6_done_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(drv_cmd) == 2'd1);

    // R5: a chirp K begins only after SE0 or a chirp J.
    a_r5_k_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_cmd == 2'd2 && $past(drv_cmd) != 2'd2) |->
        ($past(drv_cmd) == 2'd1 || $past(drv_cmd) == 2'd3));

    // R5: a chirp J always follows a chirp K.
    a_r5_j_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_cmd == 2'd3 && $past(drv_cmd) != 2'd3) |-> $past(drv_cmd) == 2'd2);

    // R6: a chirp is only cut off to idle by a disconnect.
    a_r6_no_cut_chirp: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drv_cmd[1]) && drv_cmd == 2'd0) |-> $past(disc));
endmodule

bind port_reset_chirp_seq rcs_checker u_rcs_chk (
    .clk(clk), .rst_n(rst_n), .disc(disc), .drv_cmd(drv_cmd),
    .done(done), .disc_evt(disc_evt)
);

// File: tb/test_port_reset_chirp_seq.sv
`timescale 1ns/1ps
// Bench: builds the expected drive code for each cycle of a scenario from
// the placement of the device chirp and compares it on every clock.
module test_port_reset_chirp_seq;
    localparam int RST = 400;
    localparam int FLT = 6;
    localparam int RSP = 5;
    localparam int CHR = 12;
    localparam int GRD = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic       low_spd = 1'b0;
    logic       disc = 1'b0;
    logic [1:0] line_st = 2'd0;
    logic [1:0] drv_cmd;
    logic       done;
    logic [1:0] spd;
    logic       disc_evt;

    int checks = 0;
    int errors = 0;
    int exp_cmd [0:RST];
    int first_k, tail_start, npairs;

    always #2.5 clk = ~clk;

    port_reset_chirp_seq #(
        .RST_CYC(RST), .FILT_CYC(FLT), .RESP_CYC(RSP), .CHIRP_CYC(CHR), .GUARD_CYC(GRD)
    ) i_port_reset_chirp_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .low_spd(low_spd), .disc(disc),
        .line_st(line_st), .drv_cmd(drv_cmd), .done(done), .spd(spd), .disc_evt(disc_evt)
    );

    task automatic chk(input string tag, input int act, input int exp, input int cyc);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Expected drive codes for one window from the device chirp placement.
    task automatic build(input int ks, input int kl, input int ls);
        int a, s;
        for (int i = 0; i < RST; i++) exp_cmd[i] = 1;
        exp_cmd[RST] = 0;
        first_k = -1; tail_start = -1; npairs = 0;
        if (ls == 0 && kl >= FLT && ks + FLT - 1 <= RST - 2) begin
            a = ks + kl;
            s = a + RSP + 1;
            while (s + 2 * CHR + GRD <= RST) begin
                if (first_k < 0) first_k = s;
                for (int j = 0; j < CHR; j++) begin
                    exp_cmd[s + j] = 2;
                    exp_cmd[s + CHR + j] = 3;
                end
                s += 2 * CHR;
                npairs++;
            end
            if (npairs > 0) tail_start = s;
        end
    endtask

    // One scenario: request, then a per-cycle compare until the window ends.
    task automatic run(input int ks, input int kl, input int ls, input int d,
                       input int busy_req, input string se0_tag);
        int last;
        string tag;
        build(ks, kl, ls);
        last = (d >= 0) ? d + 1 : RST;
        @(negedge clk);
        rst_req = 1'b1; low_spd = ls[0];
        @(negedge clk);
        rst_req = 1'b0;
        for (int i = 0; i <= last; i++) begin
            int ec;
            ec = (d >= 0 && i > d) ? 0 : exp_cmd[i];
            if (ec == 0)                               tag = (d >= 0) ? "R9" : "R2";
            else if (i == first_k)                     tag = "R4";
            else if (ec >= 2)                          tag = "R5";
            else if (tail_start >= 0 && i >= tail_start) tag = "R6";
            else                                       tag = se0_tag;
            chk(tag, drv_cmd, ec, i);
            chk("R2", done, (d < 0 && i == RST) ? 1 : 0, i);
            chk("R9", disc_evt, (d >= 0 && i == d + 1) ? 1 : 0, i);
            if (d < 0 && i == RST)
                chk(ls ? "R7" : "R8", spd, ls ? 1 : (npairs > 0 ? 2 : 0), i);
            line_st = (i >= ks && i < ks + kl) ? 2'd2 : 2'd0;
            disc    = (i == d);
            rst_req = (i == busy_req);
            @(negedge clk);
        end
        line_st = 2'd0; disc = 1'b0; rst_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R10", drv_cmd, 0, last + 1 + i);
            chk("R10", done, 0, last + 1 + i);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20000 * 5);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", drv_cmd, 0, 0);
        chk("R1", done, 0, 0);
        chk("R1", disc_evt, 0, 0);
        chk("R1", spd, 0, 0);
        // R2: no device chirp, full-speed result
        run(0, 0, 0, -1, -1, "R2");
        // R4 R5 R6 R8 R10: chirp accepted, pair train, busy request ignored
        run(20, 30, 0, -1, 60, "R2");
        chk("R8", spd, 2, -1);
        // R3: burst one cycle short of the filter
        run(40, FLT - 1, 0, -1, -1, "R3");
        // R7: low-speed device ignores chirp
        run(20, 30, 1, -1, -1, "R7");
        // R6: accepted late, no pair fits, full speed
        run(340, 10, 0, -1, -1, "R6");
        // R9: disconnect during chirp train
        run(20, 30, 0, 100, -1, "R9");
        chk("R8", spd, 0, -1);
        // R3: burst exactly the filter length is accepted
        run(100, FLT, 0, -1, -1, "R3");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule